// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers interrupt-pending flags from six sources of a two-channel serial controller, ranks them in a fixed priority order and drives an active-low interrupt request. Software can service requests in three ways. It can poll the vector register with no acknowledge at all. An external controller can pulse a hardware acknowledge strobe that settles through a daisy chain. Software can also read the status-bearing vector register and have that read act as the acknowledge.

A granted source gets an in-service bit. That bit locks the status vector and blocks requests of equal or lower priority until software issues the in-service reset command. The returned vector is a programmable base byte. Bits [3:1] of it can be replaced by a code that names the interrupting source. A control bit can stop the vector from being driven during a hardware acknowledge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A `src_set` bit sets the matching pending bit and a `src_clr` bit clears it; if both are high together the bit ends up set. Reading address 1 returns the pending bits in [5:0] (bit 0 channel A receive, 1 channel A transmit, 2 channel A external, 3 channel B receive, 4 channel B transmit, 5 channel B external) with zeros above.
- R2: `int_n` is low exactly when `ien_in` is high and some pending source outranks every in-service source (index 0 is highest). It is high whenever nothing is pending.
- R3: The status code of source index i is i (3'b000 to 3'b101), and 3'b111 means nothing to report. A status vector is the base byte with bits [3:1] replaced by this code.
- R4: Writing address 2 loads the base byte. Reading address 2 returns the status vector only when control bit 0 is set, and the plain base byte otherwise. Reading address 3 always returns the status vector.
- R5: With nothing in service, the status code follows the highest pending source at each read and is not latched between reads.
- R6: While a read stays asserted, `bus_rdata` holds the value from the first cycle of that read, even if the pending bits change.
- R7: Once `ack_n` has been low for SETTLE_CYCLES consecutive clock edges with `ien_in` high, the in-service bit of the highest eligible pending source is set. This happens at most once per acknowledge.
- R8: After that grant and while `ack_n` stays low, `vec_drive` is high and `bus_rdata` carries the address-2 vector if control bit 1 is 0. If control bit 1 is 1, `vec_drive` stays low and nothing is driven.
- R9: While any in-service bit is set, the status code stays that of the highest in-service source. Lower or equal pending sources do not raise `int_n`, and higher ones do.
- R10: Writing address 1 with bit 0 set clears the highest-priority in-service bit. Writing it with bit 1 set clears all pending and in-service bits but leaves the control and base registers alone. Nothing else clears an in-service bit, including clearing the source's pending bit.
- R11: When control bit 5 is set and `ien_in` is high, a read of address 3 grants the highest eligible pending source in the same way as a hardware acknowledge. When the bit is clear, that read has no side effect.
- R12: `ien_out` is low when `ien_in` is low, when any in-service bit is set, or when `ack_n` is low while any bit is pending. While `ien_in` is low, no acknowledge grants anything.
- R13: Address 0 holds the control register. Only bits 0, 1 and 5 are stored, and the other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Bus select |
| bus_rd | input | 1 | Read strobe, held for the length of the read |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, or the vector during an acknowledge |
| src_set | input | 6 | Per-source pending set pulses |
| src_clr | input | 6 | Per-source condition cleared pulses |
| ack_n | input | 1 | Hardware acknowledge strobe, active low |
| ien_in | input | 1 | Daisy-chain enable from the higher-priority neighbour |
| ien_out | output | 1 | Daisy-chain enable to the lower-priority neighbour |
| int_n | output | 1 | Interrupt request, active low |
| vec_drive | output | 1 | High while the vector is driven for an acknowledge |

## Verification
The hardest case to reach is a higher-priority request that lands in the middle of a vector read. The bench holds the read strobe across several cycles and raises a new source between its two samples of `bus_rdata`, then starts a fresh read to show that the live value has moved. Nested priority is reached by granting a mid-priority source through the acknowledge and then raising sources on both sides of it. The checks confirm that only the higher one brings `int_n` back while the status stays locked.

// File: rtl/irq_vec_pkg.sv
// Shared constants for the vectored interrupt controller.
// Assumes six sources ranked by index, index 0 the highest.
package irq_vec_pkg;
    localparam int NSRC    = 6;
    localparam int IDX_W   = 3;
    localparam int VEC_W   = 8;
    localparam int STAT_LSB = 1;
    localparam logic [IDX_W-1:0] CODE_NONE = 3'b111;

    localparam int CTL_VIS   = 0;
    localparam int CTL_NOVEC = 1;
    localparam int CTL_SWACK = 5;
    localparam logic [VEC_W-1:0] CTRL_MASK =
        VEC_W'((1 << CTL_VIS) | (1 << CTL_NOVEC) | (1 << CTL_SWACK));

    localparam int CMD_RST_IUS = 0;
    localparam int CMD_SW_RST  = 1;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_CMD   = 2'd1,
        ADDR_VEC_A = 2'd2,
        ADDR_VEC_B = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: reports whether any request is set and the
// index of the lowest-numbered (highest-priority) one.
// Assumes IDX_W is wide enough to hold N-1.
module irq_prio_pick #(
    parameter int N     = 6,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from lowest priority upward so the highest one wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ack_seq.sv
// Hardware acknowledge sequencer: counts acknowledge-low cycles, issues
// one grant pulse when the settle window ends, and remembers the grant
// until the strobe is released. Assumes SETTLE_CYCLES >= 1.
module irq_ack_seq #(
    parameter int SETTLE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    input  logic ien_in,
    input  logic cand_valid,
    output logic grant,
    output logic hit
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    logic [CW-1:0] cnt_q;

    assign grant = !ack_n && (cnt_q == CW'(SETTLE_CYCLES - 1)) && ien_in && cand_valid;

    // Settle counter and grant memory, both cleared when the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n || ack_n) begin
            cnt_q <= '0;
            hit   <= 1'b0;
        end else begin
            if (cnt_q != CW'(SETTLE_CYCLES)) cnt_q <= cnt_q + 1'b1;
            if (grant) hit <= 1'b1;
        end
    end

    // R7: a grant is remembered on the following edge.
    a_r7_hit_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> hit);
endmodule

// File: rtl/irq_vec_fmt.sv
// Vector formatter: returns the base byte, optionally with the status
// code placed in bits [3:1]. Assumes VEC_W exceeds STAT_LSB + IDX_W.
module irq_vec_fmt
    import irq_vec_pkg::*;
(
    input  logic [VEC_W-1:0] base,
    input  logic [IDX_W-1:0] code,
    input  logic             with_status,
    output logic [VEC_W-1:0] vec
);
    // Merge the code into its field when status is requested.
    always_comb begin
        vec = base;
        if (with_status) vec[STAT_LSB +: IDX_W] = code;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Vectored interrupt priority controller top. It holds the pending,
// in-service, control and base registers, serves bus reads with a
// read-freeze holder, and accepts hardware or read-triggered acknowledges.
// Assumes single-cycle writes and reads held one or more cycles.
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int SETTLE_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [VEC_W-1:0] bus_wdata,
    output logic [VEC_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]  src_set,
    input  logic [NSRC-1:0]  src_clr,
    input  logic             ack_n,
    input  logic             ien_in,
    output logic             ien_out,
    output logic             int_n,
    output logic             vec_drive
);
    logic [NSRC-1:0]  pend_q, ius_q, above, eligible;
    logic [VEC_W-1:0] ctrl_q, base_q, held_q, live_rd, vec_a, vec_b;
    logic             rd_q, cand_valid, ius_valid, hw_grant, hw_hit;
    logic [IDX_W-1:0] cand_idx, ius_idx, status_code;
    logic             rd_now, rd_start, wr_cmd, rst_ius, sw_rst, sw_grant, grant_any;
    reg_addr_e        addr;

    assign addr     = reg_addr_e'(bus_addr);
    assign rd_now   = bus_cs && bus_rd;
    assign rd_start = rd_now && !rd_q;
    assign wr_cmd   = bus_cs && bus_wr && (addr == ADDR_CMD);
    assign rst_ius  = wr_cmd && bus_wdata[CMD_RST_IUS];
    assign sw_rst   = wr_cmd && bus_wdata[CMD_SW_RST];

    // Sources not outranked by any in-service bit (own bit included).
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            acc      = acc | ius_q[i];
            above[i] = !acc;
        end
    end
    assign eligible = pend_q & above;

    irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick_pend (
        .req(eligible), .found(cand_valid), .idx(cand_idx));
    irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick_ius (
        .req(ius_q), .found(ius_valid), .idx(ius_idx));

    irq_ack_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .ien_in(ien_in),
        .cand_valid(cand_valid), .grant(hw_grant), .hit(hw_hit));

    assign sw_grant  = rd_start && (addr == ADDR_VEC_B) && ctrl_q[CTL_SWACK]
                       && ien_in && cand_valid;
    assign grant_any = hw_grant || sw_grant;

    // Status follows the in-service lock, else the best eligible request.
    always_comb begin
        if (ius_valid)       status_code = ius_idx;
        else if (cand_valid) status_code = cand_idx;
        else                 status_code = CODE_NONE;
    end

    irq_vec_fmt u_fmt_a (.base(base_q), .code(status_code),
        .with_status(ctrl_q[CTL_VIS]), .vec(vec_a));
    irq_vec_fmt u_fmt_b (.base(base_q), .code(status_code),
        .with_status(1'b1), .vec(vec_b));

    // Pending flags: condition clears first, new events then set.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) pend_q <= '0;
        else                  pend_q <= (pend_q & ~src_clr) | src_set;
    end

    // In-service flags: set by a grant, cleared only by command or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            ius_q <= '0;
        end else begin
            ius_q <= (ius_q & ~((rst_ius && ius_valid) ? (NSRC'(1) << ius_idx) : '0))
                   | (grant_any ? (NSRC'(1) << cand_idx) : '0);
        end
    end

    // Control and base registers written over the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            base_q <= '0;
        end else if (bus_cs && bus_wr) begin
            if (addr == ADDR_CTRL)  ctrl_q <= bus_wdata & CTRL_MASK;
            if (addr == ADDR_VEC_A) base_q <= bus_wdata;
        end
    end

    // Live read value selected by address.
    always_comb begin
        case (addr)
            ADDR_CTRL:  live_rd = ctrl_q;
            ADDR_CMD:   live_rd = {{(VEC_W-NSRC){1'b0}}, pend_q};
            ADDR_VEC_A: live_rd = vec_a;
            default:    live_rd = vec_b;
        endcase
    end

    // Read holder: captures the first-cycle value of each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            held_q <= '0;
        end else begin
            rd_q <= rd_now;
            if (rd_start) held_q <= live_rd;
        end
    end

    assign vec_drive = !ack_n && hw_hit && !ctrl_q[CTL_NOVEC];
    assign bus_rdata = vec_drive ? vec_a : (rd_now ? (rd_q ? held_q : live_rd) : '0);
    assign int_n     = !(cand_valid && ien_in);
    assign ien_out   = ien_in && !(|ius_q) && !(!ack_n && |pend_q);

    // R2: with nothing pending the request is inactive.
    a_r2_int_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend_q) |-> int_n);
    // R10: an in-service bit drops only after a command write.
    a_r10_ius_clear_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(ius_q) & ~ius_q)) |-> $past(rst_ius || sw_rst));
    // R7: a new in-service bit belongs to a source that was pending.
    a_r7_ius_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((ius_q & ~$past(ius_q) & ~$past(pend_q)) == '0));
    // R9: at most one source enters service per cycle.
    a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ius_q & ~$past(ius_q)) <= 1);
    // R6: a continuing read returns a steady value.
    a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && rd_now && !vec_drive && $past(!vec_drive)) |-> $stable(bus_rdata));
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE = 3;

    logic       clk = 0, rst_n = 0;
    logic       bus_cs = 0, bus_rd = 0, bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic [5:0] src_set = 0, src_clr = 0;
    logic       ack_n = 1, ien_in = 1, ien_out, int_n, vec_drive;
    int         n_chk = 0, n_fail = 0;
    logic [7:0] d, d2;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl #(.SETTLE_CYCLES(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_set(src_set), .src_clr(src_clr), .ack_n(ack_n), .ien_in(ien_in),
        .ien_out(ien_out), .int_n(int_n), .vec_drive(vec_drive));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_cs = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); bus_cs = 1; bus_rd = 1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk); bus_cs = 0; bus_rd = 0;
    endtask

    task automatic pset(input logic [5:0] m);
        @(negedge clk); src_set = m;
        @(negedge clk); src_set = 0;
    endtask

    task automatic pclr(input logic [5:0] m);
        @(negedge clk); src_clr = m;
        @(negedge clk); src_clr = 0;
    endtask

    task automatic t_reset();
        chk("R2 reset int_n", {7'd0, int_n}, 8'h01);
        chk("R12 reset ien_out", {7'd0, ien_out}, 8'h01);
        rd(2'd1, d); chk("R1 reset pending", d, 8'h00);
        rd(2'd3, d); chk("R3 reset none code", d, 8'h0E);
    endtask

    task automatic t_ctrl();
        wr(2'd0, 8'hFF); rd(2'd0, d); chk("R13 ctrl mask", d, 8'h23);
        wr(2'd0, 8'h00); rd(2'd0, d); chk("R13 ctrl clear", d, 8'h00);
    endtask

    task automatic t_pending();
        wr(2'd2, 8'hA1);
        pset(6'h10); rd(2'd1, d); chk("R1 set src4", d, 8'h10);
        chk("R2 int active", {7'd0, int_n}, 8'h00);
        pset(6'h02); rd(2'd1, d); chk("R1 set src1", d, 8'h12);
        pclr(6'h10); rd(2'd1, d); chk("R1 clear src4", d, 8'h02);
        @(negedge clk); src_set = 6'h08; src_clr = 6'h08;
        @(negedge clk); src_set = 0; src_clr = 0;
        rd(2'd1, d); chk("R1 set beats clear", d, 8'h0A);
        pclr(6'h3F); chk("R2 idle after clear", {7'd0, int_n}, 8'h01);
    endtask

    task automatic t_status();
        pset(6'h24);
        rd(2'd3, d); chk("R3 code 010 on B", d, 8'hA5);
        rd(2'd2, d); chk("R4 A plain without status bit", d, 8'hA1);
        wr(2'd0, 8'h01);
        rd(2'd2, d); chk("R4 A with status bit", d, 8'hA5);
        pclr(6'h04);
        rd(2'd3, d); chk("R5 live next code", d, 8'hAB);
        pclr(6'h3F); wr(2'd0, 8'h00);
    endtask

    task automatic t_freeze();
        pset(6'h10);
        @(negedge clk); bus_cs = 1; bus_rd = 1; bus_addr = 2'd3;
        #1 d = bus_rdata;
        @(negedge clk); src_set = 6'h01;
        @(negedge clk); src_set = 0;
        #1 d2 = bus_rdata;
        @(negedge clk); bus_cs = 0; bus_rd = 0;
        chk("R6 first sample", d, 8'hA9);
        chk("R6 held mid read", d2, 8'hA9);
        rd(2'd3, d); chk("R5 new read sees src0", d, 8'hA1);
        wr(2'd1, 8'h02);
    endtask

    task automatic t_hw_ack();
        wr(2'd0, 8'h01);
        pset(6'h08);
        @(negedge clk); ack_n = 0;
        #1 chk("R12 ien_out low during ack", {7'd0, ien_out}, 8'h00);
        repeat (SETTLE - 1) @(posedge clk);
        #1 chk("R7 no grant before settle", {7'd0, vec_drive}, 8'h00);
        @(posedge clk);
        #1 chk("R8 vector driven", {7'd0, vec_drive}, 8'h01);
        chk("R8 vector value", bus_rdata, 8'hA7);
        @(negedge clk); ack_n = 1;
        #1 chk("R9 own source blocked", {7'd0, int_n}, 8'h01);
        chk("R12 ien_out low in service", {7'd0, ien_out}, 8'h00);
        pset(6'h20);
        chk("R9 lower blocked", {7'd0, int_n}, 8'h01);
        pclr(6'h08);
        rd(2'd3, d); chk("R9 status locked", d, 8'hA7);
        chk("R10 clear pending keeps service", {7'd0, int_n}, 8'h01);
        pset(6'h02);
        chk("R9 higher raises int", {7'd0, int_n}, 8'h00);
        rd(2'd3, d); chk("R9 still locked", d, 8'hA7);
        wr(2'd1, 8'h01);
        rd(2'd3, d); chk("R10 reset in-service", d, 8'hA3);
        wr(2'd1, 8'h02);
    endtask

    task automatic t_novec();
        wr(2'd0, 8'h03);
        pset(6'h04);
        @(negedge clk); ack_n = 0;
        repeat (SETTLE + 1) @(posedge clk);
        #1 chk("R8 no vector when bit1 set", {7'd0, vec_drive}, 8'h00);
        @(negedge clk); ack_n = 1;
        #1 chk("R7 granted without vector", {7'd0, int_n}, 8'h01);
        rd(2'd3, d); chk("R7 status of granted", d, 8'hA5);
        wr(2'd1, 8'h02);
    endtask

    task automatic t_chain();
        wr(2'd0, 8'h00);
        pset(6'h01);
        @(negedge clk); ien_in = 0;
        #1 chk("R12 ien_out follows ien_in", {7'd0, ien_out}, 8'h00);
        chk("R2 int gated by ien_in", {7'd0, int_n}, 8'h01);
        ack_n = 0;
        repeat (SETTLE + 2) @(posedge clk);
        @(negedge clk); ack_n = 1; ien_in = 1;
        #1 chk("R12 no grant while chain low", {7'd0, int_n}, 8'h00);
        wr(2'd1, 8'h02);
    endtask

    task automatic t_swack();
        wr(2'd0, 8'h00);
        pset(6'h02);
        rd(2'd3, d); chk("R11 read without swack", d, 8'hA3);
        chk("R11 no side effect", {7'd0, int_n}, 8'h00);
        wr(2'd0, 8'h20);
        rd(2'd3, d); chk("R11 ack read vector", d, 8'hA3);
        chk("R11 acked", {7'd0, int_n}, 8'h01);
        pclr(6'h02); pset(6'h02);
        chk("R10 service survives pending clear", {7'd0, int_n}, 8'h01);
        wr(2'd1, 8'h02);
        rd(2'd1, d); chk("R10 sw reset pending", d, 8'h00);
        rd(2'd3, d); chk("R10 sw reset service", d, 8'hAF);
        rd(2'd0, d); chk("R10 ctrl kept", d, 8'h20);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_pending();
        t_status();
        t_freeze();
        t_hw_ack();
        t_novec();
        t_chain();
        t_swack();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule